// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block drives the two switches of a synchronous half-bridge from one pulse-width command. It produces a high-side gate enable that follows the command and a low-side gate enable that follows its inverse. The block inserts a non-overlap interval at each change of the command, and the interval is built differently in each direction.

When the command falls, the high-side enable drops at once. The low-side enable then waits until a synchronised comparator reports that the switch node is below its threshold. A timeout counter is loaded at the same moment, and it forces the low-side turn-on if the comparator stays silent; a one-cycle status flag marks such a forced turn-on. When the command rises, the low-side enable drops first. The controller then waits for the synchronised low-gate-is-low feedback, and after that it counts a programmable delay before it raises the high-side enable. A low-side enable input can disable the low-side gate on its own. An undervoltage flag forces both gates low and restarts the sequence from the all-off state.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never both high in the same cycle.
- R2: While the high side is on, the first clock edge that samples `pwm_cmd_i` low clears `hs_gate_o`.
- R3: In the wait after a command fall, `ls_gate_o` rises on the second clock edge after the first edge that samples `sw_below_i` high. The switch-node input passes through two synchroniser flops before it is used.
- R4: Let edge N be the edge at which the high side turns off, and let T be `tmo_count_i`. If the switch-node condition is never seen, `ls_gate_o` rises at edge N+1+T (T=0 gives N+1).
- R5: `tmo_forced_o` is high for exactly one cycle, in the cycle where a timeout caused the low side to turn on. It stays low when the switch-node input caused the turn-on.
- R6: The first edge that samples `pwm_cmd_i` high clears `ls_gate_o`. Let D be `dly_count_i`. If `lg_low_i` is already high and synchronised, `hs_gate_o` rises D+2 edges later. If `lg_low_i` is first sampled high at that same edge, `hs_gate_o` rises D+3 edges later.
- R7: `hs_gate_o` rises only while the command is high, and `ls_gate_o` was low in the previous cycle.
- R8: If the command reverses during the switch-node wait, the feedback wait or the delay count, the pending turn-on is dropped. The opposite sequence then starts, and the pending gate never asserts.
- R9: While `ls_en_i` is low, `ls_gate_o` is low. The high-side sequence still runs with its normal timing. Raising `ls_en_i` while the low side is in its on phase restores `ls_gate_o` in the same cycle.
- R10: While `uvlo_i` is high, both gates are low in the same cycle. After `uvlo_i` falls, both gates stay off, and the controller runs the normal sequence for the current command level. With the command high and feedback held high, `hs_gate_o` rises D+2 edges after the first edge that samples `uvlo_i` low.
- R11: During reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd_i | input | 1 | Pulse-width command; high requests the high side |
| ls_en_i | input | 1 | Low-side enable; low keeps the low-side gate off |
| uvlo_i | input | 1 | Undervoltage lockout; high forces both gates off |
| sw_below_i | input | 1 | Comparator: switch node below threshold (asynchronous) |
| lg_low_i | input | 1 | Feedback: low-side gate is low (asynchronous) |
| dly_count_i | input | CNT_W | Delay count D used before high-side turn-on |
| tmo_count_i | input | CNT_W | Timeout count T used for the forced low-side turn-on |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| tmo_forced_o | output | 1 | One-cycle pulse: low side turned on by timeout |

## Verification
The command is toggled with the switch-node and feedback levels arranged in several ways. A comparator that rises with the command fall separates the adaptive turn-on from the timeout path. A comparator that stays low exercises the forced turn-on at T=5 and T=0, and the flag pulse with it. Feedback that rises with the command, compared against feedback that is held high, tells apart the wait for the synchronised feedback and the D+3 and D+2 cases, with D taken as 0, 2 and 6. Command reversals in the delay and in the switch-node wait, a low-side disable, and lockout with release into both command levels cover the abort and override paths.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HI      = 3'd1,
    ST_WAIT_SW = 3'd2,
    ST_LO      = 3'd3,
    ST_WAIT_FB = 3'd4,
    ST_DLY     = 3'd5
  } dtg_state_e;
endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= 1'b0;
        stage2[b] <= 1'b0;
      end else begin
        stage1[b] <= d_i[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= load_val_i;
    end else if (run_i && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
  import dtg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_cmd_i,
  input  logic             ls_en_i,
  input  logic             uvlo_i,
  input  logic             sw_below_i,
  input  logic             lg_low_i,
  input  logic [CNT_W-1:0] dly_count_i,
  input  logic [CNT_W-1:0] tmo_count_i,
  output logic             hs_gate_o,
  output logic             ls_gate_o,
  output logic             tmo_forced_o
);
  localparam int NSENSE = 2;
  localparam int IDX_SW = 0;
  localparam int IDX_FB = 1;

  dtg_state_e state, state_nxt;
  logic [NSENSE-1:0] sense_raw, sense_s;
  logic sw_s, fb_s;
  logic tmo_zero, dly_zero;
  logic tmo_load, dly_load;
  logic forced_nxt, forced_q;

  assign sense_raw[IDX_SW] = sw_below_i;
  assign sense_raw[IDX_FB] = lg_low_i;

  dtg_sync #(.W(NSENSE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sense_raw),
    .q_o   (sense_s)
  );

  assign sw_s = sense_s[IDX_SW];
  assign fb_s = sense_s[IDX_FB];

  always_comb begin
    state_nxt  = state;
    forced_nxt = 1'b0;
    if (uvlo_i) begin
      state_nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     state_nxt = pwm_cmd_i ? ST_WAIT_FB : ST_WAIT_SW;
        ST_HI:      if (!pwm_cmd_i) state_nxt = ST_WAIT_SW;
        ST_WAIT_SW: begin
          if (pwm_cmd_i) begin
            state_nxt = ST_WAIT_FB;
          end else if (sw_s) begin
            state_nxt = ST_LO;
          end else if (tmo_zero) begin
            state_nxt  = ST_LO;
            forced_nxt = 1'b1;
          end
        end
        ST_LO:      if (pwm_cmd_i) state_nxt = ST_WAIT_FB;
        ST_WAIT_FB: begin
          if (!pwm_cmd_i)  state_nxt = ST_WAIT_SW;
          else if (fb_s)   state_nxt = ST_DLY;
        end
        ST_DLY: begin
          if (!pwm_cmd_i)    state_nxt = ST_WAIT_SW;
          else if (dly_zero) state_nxt = ST_HI;
        end
        default:    state_nxt = ST_OFF;
      endcase
    end
  end

  assign tmo_load = (state_nxt == ST_WAIT_SW) && (state != ST_WAIT_SW);
  assign dly_load = (state_nxt == ST_DLY) && (state != ST_DLY);

  dtg_timer #(.CNT_W(CNT_W)) u_tmo_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmo_load),
    .load_val_i (tmo_count_i),
    .run_i      (state == ST_WAIT_SW),
    .zero_o     (tmo_zero)
  );

  dtg_timer #(.CNT_W(CNT_W)) u_dly_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (dly_load),
    .load_val_i (dly_count_i),
    .run_i      (state == ST_DLY),
    .zero_o     (dly_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      forced_q <= 1'b0;
    end else begin
      state    <= state_nxt;
      forced_q <= forced_nxt;
    end
  end

  assign hs_gate_o    = (state == ST_HI) && !uvlo_i;
  assign ls_gate_o    = (state == ST_LO) && ls_en_i && !uvlo_i;
  assign tmo_forced_o = forced_q;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_cmd_i,
  input logic ls_en_i,
  input logic uvlo_i,
  input logic hs_gate_o,
  input logic ls_gate_o,
  input logic tmo_forced_o
);
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o));

  assert_hs_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate_o && !pwm_cmd_i && !uvlo_i) |=> !hs_gate_o);

  assert_ls_after_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> $past(!hs_gate_o));

  assert_flag_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_forced_o |=> !tmo_forced_o);

  assert_flag_no_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_forced_o |-> !hs_gate_o);

  assert_ls_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate_o && pwm_cmd_i) |=> !ls_gate_o);

  assert_hs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (pwm_cmd_i && $past(pwm_cmd_i) && $past(!ls_gate_o)));

  assert_ls_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_en_i |-> !ls_gate_o);

  assert_uvlo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (!hs_gate_o && !ls_gate_o));
endmodule

bind deadtime_gate_ctrl dtg_checker u_dtg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_cmd_i    (pwm_cmd_i),
  .ls_en_i      (ls_en_i),
  .uvlo_i       (uvlo_i),
  .hs_gate_o    (hs_gate_o),
  .ls_gate_o    (ls_gate_o),
  .tmo_forced_o (tmo_forced_o)
);

// File: tb/deadtime_gate_ctrl_bench.sv
module deadtime_gate_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_cmd_i = 1'b0;
  logic ls_en_i = 1'b1;
  logic uvlo_i = 1'b0;
  logic sw_below_i = 1'b1;
  logic lg_low_i = 1'b1;
  logic [CNT_W-1:0] dly_count_i = 8'd2;
  logic [CNT_W-1:0] tmo_count_i = 8'd5;
  logic hs_gate_o, ls_gate_o, tmo_forced_o;

  deadtime_gate_ctrl #(.CNT_W(CNT_W)) u_deadtime_gate_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_cmd_i    (pwm_cmd_i),
    .ls_en_i      (ls_en_i),
    .uvlo_i       (uvlo_i),
    .sw_below_i   (sw_below_i),
    .lg_low_i     (lg_low_i),
    .dly_count_i  (dly_count_i),
    .tmo_count_i  (tmo_count_i),
    .hs_gate_o    (hs_gate_o),
    .ls_gate_o    (ls_gate_o),
    .tmo_forced_o (tmo_forced_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    hs;
    bit    ls;
    bit    fl;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input bit hs, input bit ls, input bit fl, input string req);
    n_cmp++;
    if (hs_gate_o !== hs || ls_gate_o !== ls || tmo_forced_o !== fl) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual hs=%b ls=%b flag=%b expected hs=%b ls=%b flag=%b",
               req, cyc, hs_gate_o, ls_gate_o, tmo_forced_o, hs, ls, fl);
    end
  endtask

  // Monitor: pops scheduled expectations and compares against outputs.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s missed slot %0d actual cyc=%0d expected cyc=%0d", e.req, e.cyc, cyc, e.cyc);
      end else begin
        compare(e.hs, e.ls, e.fl, e.req);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int d, input bit hs, input bit ls, input bit fl, input string req);
    exp_t e;
    e.cyc = cyc + d;
    e.hs = hs;
    e.ls = ls;
    e.fl = fl;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic check_now(input bit hs, input bit ls, input bit fl, input string req);
    #1;
    compare(hs, ls, fl, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    check_now(1'b0, 1'b0, 1'b0, "R11");
    rst_n = 1'b1;
    step(8);
    check_now(1'b0, 1'b1, 1'b0, "R3");

    // R6: feedback rises with the command, D=2 -> high side at D+3
    lg_low_i = 1'b0;
    step(3);
    pwm_cmd_i = 1'b1; lg_low_i = 1'b1; sw_below_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(5, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(6, 1'b1, 1'b0, 1'b0, "R6");
    drain();

    // R2/R3: command falls with switch node low already reported
    pwm_cmd_i = 1'b0; sw_below_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R2");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R3");
    expect_at(3, 1'b0, 1'b1, 1'b0, "R3");
    drain();

    // R6: feedback held high, D=0 -> high side at D+2
    dly_count_i = 8'd0;
    pwm_cmd_i = 1'b1; sw_below_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(3, 1'b1, 1'b0, 1'b0, "R6");
    drain();

    // R4/R5: timeout T=5, comparator silent
    pwm_cmd_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R2");
    expect_at(6, 1'b0, 1'b0, 1'b0, "R4");
    expect_at(7, 1'b0, 1'b1, 1'b1, "R5");
    expect_at(8, 1'b0, 1'b1, 1'b0, "R5");
    drain();

    // R4/R5: timeout T=0
    dly_count_i = 8'd2;
    pwm_cmd_i = 1'b1;
    expect_at(4, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(5, 1'b1, 1'b0, 1'b0, "R6");
    drain();
    tmo_count_i = 8'd0;
    pwm_cmd_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R4");
    expect_at(2, 1'b0, 1'b1, 1'b1, "R4");
    expect_at(3, 1'b0, 1'b1, 1'b0, "R5");
    drain();
    tmo_count_i = 8'd5;

    // R8: command reverses during the delay count (D=6)
    dly_count_i = 8'd6;
    pwm_cmd_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(3, 1'b0, 1'b0, 1'b0, "R8");
    step(3);
    pwm_cmd_i = 1'b0; sw_below_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(3, 1'b0, 1'b1, 1'b0, "R8");
    drain();

    // R8: command reverses during the switch-node wait
    dly_count_i = 8'd2;
    pwm_cmd_i = 1'b1; sw_below_i = 1'b0;
    expect_at(5, 1'b1, 1'b0, 1'b0, "R6");
    drain();
    pwm_cmd_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8");
    step(2);
    pwm_cmd_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(4, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(5, 1'b1, 1'b0, 1'b0, "R8");
    drain();

    // R9: low-side disable
    ls_en_i = 1'b0;
    pwm_cmd_i = 1'b0; sw_below_i = 1'b1;
    expect_at(3, 1'b0, 1'b0, 1'b0, "R9");
    expect_at(4, 1'b0, 1'b0, 1'b0, "R9");
    drain();
    pwm_cmd_i = 1'b1; sw_below_i = 1'b0;
    expect_at(4, 1'b0, 1'b0, 1'b0, "R9");
    expect_at(5, 1'b1, 1'b0, 1'b0, "R9");
    drain();
    pwm_cmd_i = 1'b0; sw_below_i = 1'b1;
    expect_at(3, 1'b0, 1'b0, 1'b0, "R9");
    drain();
    ls_en_i = 1'b1;
    check_now(1'b0, 1'b1, 1'b0, "R9");

    // R10: lockout
    pwm_cmd_i = 1'b1; sw_below_i = 1'b0;
    expect_at(5, 1'b1, 1'b0, 1'b0, "R6");
    drain();
    uvlo_i = 1'b1;
    check_now(1'b0, 1'b0, 1'b0, "R10");
    pwm_cmd_i = 1'b0; sw_below_i = 1'b1;
    step(5);
    check_now(1'b0, 1'b0, 1'b0, "R10");
    pwm_cmd_i = 1'b1;
    step(3);
    check_now(1'b0, 1'b0, 1'b0, "R10");
    uvlo_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R10");
    expect_at(4, 1'b0, 1'b0, 1'b0, "R10");
    expect_at(5, 1'b1, 1'b0, 1'b0, "R10");
    drain();
    uvlo_i = 1'b1;
    pwm_cmd_i = 1'b0;
    step(3);
    check_now(1'b0, 1'b0, 1'b0, "R10");
    uvlo_i = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R10");
    expect_at(2, 1'b0, 1'b1, 1'b0, "R10");
    drain();

    step(2);
    finish_run();
  end
endmodule